// File: doc/BRIEF.md
# Pending Interrupt Bit Array

This block keeps one pending flag per interrupt vector. These flags show which vectors hold a message that could not be sent yet. The flags are packed into 64-bit words. Vector `v` lives in word `v / 64` at bit `v % 64`. The array holds `NUM_VEC / 64 + 1` words, so its capacity is `CAP = WORDS * 64` bits. Every flag is zero after reset.

The interrupt logic around the block decides when a flag should rise or fall. It does this through two internal ports, one for set and one for clear, each addressed by vector number. A combinational query port reports the flag of any single vector.

Software sees the array only through a read view with byte offsets. The view serves aligned 32-bit and 64-bit reads and returns data one cycle later. Software writes do nothing to the flags; each write only raises a one-cycle error pulse.

Top module: `pend_bit_array`

## Requirements
- R1: While `rst` is high at a clock edge, every flag clears, and `rd_vld` and `wr_err` go low on that edge.
- R2: A `set_vld` at an edge with `set_vec` below `CAP` raises bit `set_vec % 64` of word `set_vec / 64`. The flag is visible from the cycle after that edge.
- R3: A `clr_vld` at an edge with `clr_vec` below `CAP` lowers that vector's flag. A clear on one vector does not disturb a set on a different vector in the same cycle.
- R4: When set and clear name the same vector in the same cycle, the flag ends up set.
- R5: Set and clear with a vector number at or above `CAP` change nothing. Querying such a vector returns 0. Vector numbers are 11 bits, so they range from 0 to 2047.
- R6: `qry_pend` follows `qry_vec` combinationally, with no clock edge needed.
- R7: A read (`rd_en`) with `rd_wide`=0 gives its result one cycle later, with `rd_vld`=1. The word index is `rd_off[15:3]` and the sub-offset is `rd_off[2:0]`:
  - sub-offset 0 returns bits 31:0 of the word in `rd_data[31:0]`;
  - sub-offset 4 returns bits 63:32 of the word in `rd_data[31:0]`;
  - `rd_data[63:32]` is always 0;
  - any other sub-offset returns 0.
- R8: A read with `rd_wide`=1 at sub-offset 0 returns the whole 64-bit word. At any other sub-offset it returns 0.
- R9: A read whose word index is `WORDS` or above returns 0.
- R10: A `wr_en` changes no flag. It pulses `wr_err` high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_vld | input | 1 | Raise the flag of `set_vec` |
| set_vec | input | 11 | Vector to set |
| clr_vld | input | 1 | Lower the flag of `clr_vec` |
| clr_vec | input | 11 | Vector to clear |
| qry_vec | input | 11 | Vector whose flag is reported |
| qry_pend | output | 1 | Current flag of `qry_vec` |
| rd_en | input | 1 | Bus read strobe |
| rd_off | input | 16 | Byte offset of the read |
| rd_wide | input | 1 | 1 = 64-bit read, 0 = 32-bit read |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| wr_en | input | 1 | Bus write strobe (rejected) |
| wr_err | output | 1 | Write-rejected pulse |

## Verification
On every cycle, the assertions check the following:
- a set or a clear lands on the addressed flag;
- set wins over clear on the same vector;
- the flags hold still when neither internal port is active;
- an out-of-range query reads 0;
- the read valid and write error follow their strobes by one cycle;
- misaligned, out-of-range and upper-half-of-32-bit read data stay zero.

Only the bench scenarios can show two things. The first is that a read returns the right word half from a built-up bit pattern. The second is that a bus write leaves the whole pattern intact; the bench shows this by sweeping every vector and every offset against its own model.

// File: rtl/pba_pkg.sv
package pba_pkg;
  localparam int VEC_W  = 11;          // vector numbers 0..2047
  localparam int OFF_W  = 16;          // byte offset width of the read view
  localparam int WORD_W = 64;          // flags per word
  localparam int BIT_W  = 6;           // log2(WORD_W)
  localparam int WI_W   = VEC_W - BIT_W;

  typedef enum logic {
    RD_HALF = 1'b0,
    RD_FULL = 1'b1
  } rd_size_e;

  function automatic int words_for(input int nvec);
    return nvec / WORD_W + 1;
  endfunction
endpackage

// File: rtl/pba_store.sv
module pba_store
  import pba_pkg::*;
#(
  parameter int WORDS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    set_vld,
  input  logic [VEC_W-1:0]        set_vec,
  input  logic                    clr_vld,
  input  logic [VEC_W-1:0]        clr_vec,
  output logic [WORDS*WORD_W-1:0] pend_flat
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              set_hit;
    logic              clr_hit;

    assign set_hit = set_vld && (set_vec[VEC_W-1:BIT_W] == WI_W'(g));
    assign clr_hit = clr_vld && (clr_vec[VEC_W-1:BIT_W] == WI_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else begin
        if (clr_hit) word_q[clr_vec[BIT_W-1:0]] <= 1'b0;
        // the later assignment wins: set has priority
        if (set_hit) word_q[set_vec[BIT_W-1:0]] <= 1'b1;
      end
    end

    assign pend_flat[g*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/pba_query.sv
module pba_query
  import pba_pkg::*;
#(
  parameter int CAP = 128
) (
  input  logic [CAP-1:0]   pend_flat,
  input  logic [VEC_W-1:0] qry_vec,
  output logic             qry_pend
);
  localparam int IDX_W = $clog2(CAP);

  always_comb begin
    if (32'(qry_vec) < CAP) qry_pend = pend_flat[qry_vec[IDX_W-1:0]];
    else                    qry_pend = 1'b0;
  end
endmodule

// File: rtl/pba_rdport.sv
module pba_rdport
  import pba_pkg::*;
#(
  parameter int WORDS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_en,
  input  logic [OFF_W-1:0]        rd_off,
  input  logic                    rd_wide,
  input  logic [WORDS*WORD_W-1:0] pend_flat,
  output logic                    rd_vld,
  output logic [WORD_W-1:0]       rd_data
);
  logic [OFF_W-4:0]  widx;
  logic [2:0]        sub;
  logic [WORD_W-1:0] word_sel;
  logic [WORD_W-1:0] rd_next;
  rd_size_e          size;

  assign widx = rd_off[OFF_W-1:3];
  assign sub  = rd_off[2:0];
  assign size = rd_size_e'(rd_wide);

  always_comb begin
    word_sel = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (32'(widx) == i) word_sel = pend_flat[i*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    rd_next = '0;
    case (size)
      RD_FULL: if (sub == 3'd0) rd_next = word_sel;
      RD_HALF: begin
        if (sub == 3'd0)      rd_next = {32'h0, word_sel[31:0]};
        else if (sub == 3'd4) rd_next = {32'h0, word_sel[63:32]};
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/pend_bit_array.sv
module pend_bit_array
  import pba_pkg::*;
#(
  parameter int NUM_VEC = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_vld,
  input  logic [VEC_W-1:0]  set_vec,
  input  logic              clr_vld,
  input  logic [VEC_W-1:0]  clr_vec,
  input  logic [VEC_W-1:0]  qry_vec,
  output logic              qry_pend,
  input  logic              rd_en,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic              rd_wide,
  output logic              rd_vld,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  output logic              wr_err
);
  localparam int WORDS = words_for(NUM_VEC);
  localparam int CAP   = WORDS * WORD_W;

  logic [CAP-1:0] pend_flat;

  pba_store #(.WORDS(WORDS)) u_store (
    .clk       (clk),
    .rst       (rst),
    .set_vld   (set_vld),
    .set_vec   (set_vec),
    .clr_vld   (clr_vld),
    .clr_vec   (clr_vec),
    .pend_flat (pend_flat)
  );

  pba_query #(.CAP(CAP)) u_query (
    .pend_flat (pend_flat),
    .qry_vec   (qry_vec),
    .qry_pend  (qry_pend)
  );

  pba_rdport #(.WORDS(WORDS)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .rd_off    (rd_off),
    .rd_wide   (rd_wide),
    .pend_flat (pend_flat),
    .rd_vld    (rd_vld),
    .rd_data   (rd_data)
  );

  // bus writes never reach the flags; they only raise the reject pulse
  always_ff @(posedge clk) begin
    if (rst) wr_err <= 1'b0;
    else     wr_err <= wr_en;
  end
endmodule

// File: rtl/pba_chk.sv
module pba_chk
  import pba_pkg::*;
#(
  parameter int WORDS = 2,
  parameter int CAP   = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              set_vld,
  input logic [VEC_W-1:0]  set_vec,
  input logic              clr_vld,
  input logic [VEC_W-1:0]  clr_vec,
  input logic [VEC_W-1:0]  qry_vec,
  input logic              qry_pend,
  input logic              rd_en,
  input logic [OFF_W-1:0]  rd_off,
  input logic              rd_wide,
  input logic              rd_vld,
  input logic [WORD_W-1:0] rd_data,
  input logic              wr_en,
  input logic              wr_err,
  input logic [CAP-1:0]    pend_flat
);
  logic [2047:0] pend_ext;
  assign pend_ext = 2048'(pend_flat);

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (pend_flat == '0 && !rd_vld && !wr_err)); // R1
  AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst) (set_vld && 32'(set_vec) < CAP) |=> pend_ext[$past(set_vec)]); // R2
  AST_CLR_LANDS: assert property (@(posedge clk) disable iff (rst) (clr_vld && 32'(clr_vec) < CAP && !(set_vld && set_vec == clr_vec)) |=> !pend_ext[$past(clr_vec)]); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) (set_vld && clr_vld && set_vec == clr_vec && 32'(set_vec) < CAP) |=> pend_ext[$past(set_vec)]); // R4
  AST_OOR_QUERY: assert property (@(posedge clk) disable iff (rst) (32'(qry_vec) >= CAP) |-> !qry_pend); // R5
  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst) rd_en |=> rd_vld); // R7
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst) !rd_en |=> !rd_vld); // R7
  AST_RD_HALF_UPPER: assert property (@(posedge clk) disable iff (rst) (rd_en && !rd_wide) |=> rd_data[63:32] == 32'h0); // R7
  AST_RD_MISALIGN: assert property (@(posedge clk) disable iff (rst) (rd_en && rd_off[1:0] != 2'b00) |=> rd_data == '0); // R8
  AST_RD_BEYOND: assert property (@(posedge clk) disable iff (rst) (rd_en && 32'(rd_off[OFF_W-1:3]) >= WORDS) |=> rd_data == '0); // R9
  AST_WR_FLAG: assert property (@(posedge clk) disable iff (rst) wr_en |=> wr_err); // R10
  AST_WR_QUIET: assert property (@(posedge clk) disable iff (rst) !wr_en |=> !wr_err); // R10
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst) (!set_vld && !clr_vld) |=> $stable(pend_flat)); // R10
endmodule

bind pend_bit_array pba_chk #(.WORDS(WORDS), .CAP(CAP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .set_vld   (set_vld),
  .set_vec   (set_vec),
  .clr_vld   (clr_vld),
  .clr_vec   (clr_vec),
  .qry_vec   (qry_vec),
  .qry_pend  (qry_pend),
  .rd_en     (rd_en),
  .rd_off    (rd_off),
  .rd_wide   (rd_wide),
  .rd_vld    (rd_vld),
  .rd_data   (rd_data),
  .wr_en     (wr_en),
  .wr_err    (wr_err),
  .pend_flat (pend_flat)
);

// File: tb/pend_bit_array_tb.sv
`timescale 1ns/1ps
module pend_bit_array_tb;
  localparam int NVEC = 100;
  localparam int NW   = NVEC / 64 + 1;   // 2 words
  localparam int NCAP = NW * 64;          // 128 flags

  logic        clk = 1'b0;
  logic        rst;
  logic        set_vld, clr_vld, rd_en, rd_wide, wr_en;
  logic [10:0] set_vec, clr_vec, qry_vec;
  logic [15:0] rd_off;
  logic        qry_pend, rd_vld, wr_err;
  logic [63:0] rd_data;

  logic [NCAP-1:0] model;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pend_bit_array #(.NUM_VEC(NVEC)) u_dut (
    .clk(clk), .rst(rst),
    .set_vld(set_vld), .set_vec(set_vec),
    .clr_vld(clr_vld), .clr_vec(clr_vec),
    .qry_vec(qry_vec), .qry_pend(qry_pend),
    .rd_en(rd_en), .rd_off(rd_off), .rd_wide(rd_wide),
    .rd_vld(rd_vld), .rd_data(rd_data),
    .wr_en(wr_en), .wr_err(wr_err)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_read(input int off, input bit wide);
    int w = off >> 3;
    int s = off & 7;
    logic [63:0] word;
    if (w >= NW) return 64'h0;
    word = model[w*64 +: 64];
    if (wide) return (s == 0) ? word : 64'h0;
    if (s == 0) return {32'h0, word[31:0]};
    if (s == 4) return {32'h0, word[63:32]};
    return 64'h0;
  endfunction

  // combinational sweep of the query port, no clock edge involved (R6)
  task automatic query_sweep(input string req);
    for (int v = 0; v < 260; v++) begin
      qry_vec = 11'(v);
      #0.1;
      check(req, {63'h0, qry_pend}, {63'h0, (v < NCAP) ? model[v] : 1'b0});
    end
  endtask

  task automatic read_sweep(input string req);
    for (int off = 0; off < 40; off++) begin
      for (int wd = 0; wd < 2; wd++) begin
        rd_en = 1'b1; rd_off = 16'(off); rd_wide = wd[0];
        tick;
        rd_en = 1'b0;
        check("R7 valid", {63'h0, rd_vld}, 64'h1);
        if ((off >> 3) >= NW) check("R9", rd_data, exp_read(off, wd[0]));
        else if (wd == 1)     check("R8", rd_data, exp_read(off, 1'b1));
        else                  check(req, rd_data, exp_read(off, 1'b0));
      end
    end
    rd_en = 1'b1; rd_off = 16'h0100; rd_wide = 1'b1;   // word 32, far beyond
    tick;
    rd_en = 1'b0;
    check("R9", rd_data, 64'h0);
  endtask

  task automatic set_one(input int v);
    set_vld = 1'b1; set_vec = 11'(v);
    tick;
    set_vld = 1'b0;
    if (v < NCAP) model[v] = 1'b1;
  endtask

  task automatic clr_one(input int v);
    clr_vld = 1'b1; clr_vec = 11'(v);
    tick;
    clr_vld = 1'b0;
    if (v < NCAP) model[v] = 1'b0;
  endtask

  initial begin
    #1000000;   // 200,000 cycles at 5 ns
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; set_vld = 0; clr_vld = 0; rd_en = 0; rd_wide = 0; wr_en = 0;
    set_vec = 0; clr_vec = 0; qry_vec = 0; rd_off = 0;
    model = '0;
    repeat (3) tick;
    rst = 1'b0;
    check("R1 rd_vld", {63'h0, rd_vld}, 64'h0);
    check("R1 wr_err", {63'h0, wr_err}, 64'h0);
    query_sweep("R1");

    // R2: build a pattern one vector per cycle
    for (int v = 0; v < NCAP; v++) begin
      if ((v * 37) % 5 < 2) begin
        set_one(v);
        qry_vec = 11'(v);
        #0.1;
        check("R2", {63'h0, qry_pend}, 64'h1);
      end
    end
    // R5: vectors beyond capacity are dropped
    set_one(130); set_one(2047);
    clr_one(200);
    query_sweep("R5");
    read_sweep("R7");

    // R3: clear every third vector
    for (int v = 0; v < NCAP; v += 3) clr_one(v);
    query_sweep("R3");

    // R4: same vector set and cleared together
    set_vld = 1'b1; set_vec = 11'd6; clr_vld = 1'b1; clr_vec = 11'd6;
    tick;
    set_vld = 1'b0; clr_vld = 1'b0; model[6] = 1'b1;
    qry_vec = 11'd6; #0.1;
    check("R4", {63'h0, qry_pend}, 64'h1);
    // R3: different vectors in the same cycle
    set_one(1);
    set_vld = 1'b1; set_vec = 11'd64; clr_vld = 1'b1; clr_vec = 11'd1;
    tick;
    set_vld = 1'b0; clr_vld = 1'b0; model[64] = 1'b1; model[1] = 1'b0;
    query_sweep("R3");

    // R6: query follows the input with no edge
    qry_vec = 11'd6;  #0.1; check("R6", {63'h0, qry_pend}, 64'h1);
    qry_vec = 11'd3;  #0.1; check("R6", {63'h0, qry_pend}, 64'h0);

    // R10: writes rejected, flags untouched
    wr_en = 1'b1;
    tick;
    wr_en = 1'b0;
    check("R10 pulse", {63'h0, wr_err}, 64'h1);
    tick;
    check("R10 end", {63'h0, wr_err}, 64'h0);
    query_sweep("R10");
    read_sweep("R10");

    // R1: reset mid-run clears everything
    rst = 1'b1;
    tick;
    rst = 1'b0; model = '0;
    query_sweep("R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule